// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Status Register

This block keeps the eight-bit status byte of a small serial EEPROM and decides, in the cycle a command arrives, whether a status write or an array write may go ahead. The command decoder in front of it supplies one strobe per decoded command: set write-enable, clear write-enable, status write with a data byte, and array write with a byte address. It also supplies the active-low write-protect pin and a completion pulse from the internal write-cycle timer. The block returns the status byte for reads, a busy flag, and a grant or reject pulse for each status or array write.

Three protections are layered. A write-enable latch must be set before any write is accepted, and it falls again when a write cycle ends. A two-bit block-protect level fences off the top quarter, the top half or the whole array whatever the other protections say. A hardware lock, formed by the lock-enable bit and a low protect pin, makes the status byte read-only and keeps the lock-enable bit from being cleared while the pin stays low. The array size (16 KiB or 32 KiB) is a parameter, and the protected ranges scale with it. The non-volatile bits are modelled as registers with a reset value.

Top module: `eeprom_wprot_status`

## Requirements
- R1: After reset the status byte reads 0x00 and busy is 0.
- R2: The set-write-enable strobe, while idle, sets the write-enable bit (status bit 1). The clear-write-enable strobe, while idle, clears it.
- R3: While busy, the status byte reads 0xFF. Every strobe is ignored: no grant, no reject, no change to write-enable, protect level or lock-enable.
- R4: While write-enable is 0, every status write and every array write is rejected.
- R5: The protect level is status bits 3:2. Level 0 protects nothing. Level 1 protects addresses at or above 3/4 of the array size. Level 2 protects addresses at or above 1/2 of the size. Level 3 protects every address. An array write into a protected address is rejected.
- R6: A protected-range reject happens whatever the state of write-enable, lock-enable and the protect pin.
- R7: Status bits 6:4 take any written value, keep nothing and always read 0 while idle.
- R8: When the protect pin is low and lock-enable (status bit 7) is 1, status writes are rejected. Array writes outside the protected range are still granted.
- R9: Lock-enable cannot fall from 1 to 0 while the protect pin is low. With the pin high, a granted status write may clear it.
- R10: A granted write sets busy (status bit 0) and holds it until the timer completion pulse. Completion clears busy and write-enable. A rejected write leaves busy at 0 and changes no state.
- R11: A granted status write loads bit 7 into lock-enable and bits 3:2 into the protect level. It does not change write-enable.
- R12: The array-size parameter selects the range bounds: for 16 KiB, 0x3000, 0x2000 and 0x0000; for 32 KiB, 0x6000, 0x4000 and 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_en | input | 1 | Set-write-enable strobe |
| cmd_wr_dis | input | 1 | Clear-write-enable strobe |
| cmd_stat_wr | input | 1 | Status-write strobe |
| stat_wdata | input | 8 | Data byte for a status write |
| cmd_arr_wr | input | 1 | Array-write strobe |
| arr_addr | input | ADDR_W | Byte address of an array write |
| wp_n | input | 1 | Active-low write-protect pin |
| cycle_done | input | 1 | Completion pulse from the write-cycle timer |
| status_q | output | 8 | Status byte for reads |
| busy | output | 1 | A write cycle is in progress |
| stat_grant | output | 1 | The status write of this cycle is accepted |
| stat_reject | output | 1 | The status write of this cycle is refused |
| arr_grant | output | 1 | The array write of this cycle is accepted |
| arr_reject | output | 1 | The array write of this cycle is refused |

## Verification
The array-write decision is tried at each protect level and at both array sizes. The addresses used are one below each range bound, the bound itself, the last address and address zero, so an off-by-one or a bound scaled to the wrong size shows up. Status writes are sent with each pin and lock-enable combination, and with the unused bits set. These cases separate the hardware lock from the plain write-enable gate, and they catch the lock-enable bit being cleared while the pin is low. Commands sent during a write cycle, then seeded random command streams with random pin levels and timer pulses, show whether busy really blocks every command and whether completion clears write-enable.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_level_e;

  localparam logic [7:0] STAT_BUSY_VALUE = 8'hFF;

  // Bit positions inside the status byte.
  localparam int BIT_READY = 0;
  localparam int BIT_WEN   = 1;
  localparam int BIT_LVL_L = 2;
  localparam int BIT_LVL_H = 3;
  localparam int BIT_LOCK  = 7;

  function automatic logic [7:0] make_status(input logic lock_en,
                                             input prot_level_e lvl,
                                             input logic wen);
    logic [7:0] s;
    s = 8'h00;
    s[BIT_LOCK]              = lock_en;
    s[BIT_LVL_H:BIT_LVL_L]   = lvl;
    s[BIT_WEN]               = wen;
    return s;
  endfunction

endpackage

// File: rtl/wprot_range_chk.sv
module wprot_range_chk
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  prot_level_e       level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  // The two top address bits tell which quarter of the array is addressed.
  function automatic logic in_fence(input prot_level_e lv,
                                    input logic [1:0] quarter);
    case (lv)
      LVL_QUARTER: return quarter == 2'b11;
      LVL_HALF:    return quarter[1];
      LVL_ALL:     return 1'b1;
      default:     return 1'b0;
    endcase
  endfunction

  logic [1:0] quarter;
  assign quarter = addr[ADDR_W-1 -: 2];
  assign hit     = in_fence(level, quarter);

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic wen,
  input  logic lock_en,
  input  logic wp_n,
  input  logic range_hit,
  input  logic req_stat,
  input  logic req_arr,
  output logic hw_lock,
  output logic stat_grant,
  output logic stat_reject,
  output logic arr_grant,
  output logic arr_reject
);

  logic stat_live, arr_live;

  assign hw_lock   = lock_en & ~wp_n;
  assign stat_live = req_stat & ~busy;
  assign arr_live  = req_arr  & ~busy;

  assign stat_grant  = stat_live & wen & ~hw_lock;
  assign stat_reject = stat_live & ~(wen & ~hw_lock);
  assign arr_grant   = arr_live & wen & ~range_hit;
  assign arr_reject  = arr_live & ~(wen & ~range_hit);

  p_wen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_grant || arr_grant) |-> wen);
  p_range_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_arr && range_hit && !busy) |-> (arr_reject && !arr_grant));
  p_hw_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stat && !wp_n && lock_en) |-> !stat_grant);
  p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(stat_grant || stat_reject || arr_grant || arr_reject));

endmodule

// File: rtl/wprot_busy_ctl.sv
module wprot_busy_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cycle_done,
  output logic busy_q,
  output logic cycle_end
);

  assign cycle_end = busy_q & cycle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (cycle_end) busy_q <= 1'b0;
    else if (start)     busy_q <= 1'b1;
  end

  p_rdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cycle_done) |=> busy_q);
  p_rdy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !busy_q);
  p_rdy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
  import wprot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        wp_n,
  input  logic        set_wen,
  input  logic        clr_wen,
  input  logic        cycle_end,
  input  logic        load_stat,
  input  logic [7:0]  wdata,
  output logic        wen_q,
  output logic        lock_q,
  output prot_level_e level_q
);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{wdata[6:4], wdata[BIT_WEN], wdata[BIT_READY]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (cycle_end || (clr_wen && !busy)) begin
      wen_q <= 1'b0;
    end else if (set_wen && !busy) begin
      wen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      level_q <= LVL_NONE;
    end else if (load_stat) begin
      lock_q  <= wdata[BIT_LOCK];
      level_q <= prot_level_e'(wdata[BIT_LVL_H:BIT_LVL_L]);
    end
  end

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(wp_n));
  p_busy_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_end) |=> ($stable(lock_q) && $stable(level_q) && $stable(wen_q)));
  p_end_clears_wen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !wen_q);

endmodule

// File: rtl/eeprom_wprot_status.sv
module eeprom_wprot_status
  import wprot_pkg::*;
#(
  parameter int ARRAY_BYTES = 16384,
  localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_en,
  input  logic              cmd_wr_dis,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              cycle_done,
  output logic [7:0]        status_q,
  output logic              busy,
  output logic              stat_grant,
  output logic              stat_reject,
  output logic              arr_grant,
  output logic              arr_reject
);

  logic        wen_q, lock_q, range_hit, hw_lock, cycle_end, busy_q;
  prot_level_e level_q;

  wprot_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .level (level_q),
    .addr  (arr_addr),
    .hit   (range_hit)
  );

  wprot_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy_q),
    .wen         (wen_q),
    .lock_en     (lock_q),
    .wp_n        (wp_n),
    .range_hit   (range_hit),
    .req_stat    (cmd_stat_wr),
    .req_arr     (cmd_arr_wr),
    .hw_lock     (hw_lock),
    .stat_grant  (stat_grant),
    .stat_reject (stat_reject),
    .arr_grant   (arr_grant),
    .arr_reject  (arr_reject)
  );

  wprot_busy_ctl u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (stat_grant | arr_grant),
    .cycle_done (cycle_done),
    .busy_q     (busy_q),
    .cycle_end  (cycle_end)
  );

  wprot_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .wp_n      (wp_n),
    .set_wen   (cmd_wr_en),
    .clr_wen   (cmd_wr_dis),
    .cycle_end (cycle_end),
    .load_stat (stat_grant),
    .wdata     (stat_wdata),
    .wen_q     (wen_q),
    .lock_q    (lock_q),
    .level_q   (level_q)
  );

  assign busy     = busy_q;
  assign status_q = busy_q ? STAT_BUSY_VALUE : make_status(lock_q, level_q, wen_q);

  p_busy_reads_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status_q == 8'hFF));
  p_spare_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_q[6:4] == 3'b000));
  p_lock_blocks_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> $stable(lock_q));
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_grant && stat_reject) && !(arr_grant && arr_reject));

endmodule

// File: tb/eeprom_wprot_status_tb.sv
module wprot_bench #(
  parameter int BYTES = 16384,
  parameter int SEED  = 1
) ();
  localparam int AW = $clog2(BYTES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_en = 0, c_dis = 0, c_sw = 0, c_aw = 0, pin_n = 1, done_p = 0;
  logic [7:0] wd = 0;
  logic [AW-1:0] ad = 0;
  logic [7:0] st;
  logic bz, sg, sr, ag, ar;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit m_wen = 0, m_busy = 0, m_lock = 0;
  bit [1:0] m_lvl = 0;

  always #5 clk = ~clk;

  eeprom_wprot_status #(.ARRAY_BYTES(BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(c_en), .cmd_wr_dis(c_dis),
    .cmd_stat_wr(c_sw), .stat_wdata(wd), .cmd_arr_wr(c_aw), .arr_addr(ad),
    .wp_n(pin_n), .cycle_done(done_p), .status_q(st), .busy(bz),
    .stat_grant(sg), .stat_reject(sr), .arr_grant(ag), .arr_reject(ar));

  // Protected when address is at or beyond the level's lower bound.
  function automatic bit guarded(bit [1:0] lv, int a);
    int lo;
    case (lv)
      2'd1: lo = BYTES - BYTES / 4;
      2'd2: lo = BYTES / 2;
      2'd3: lo = 0;
      default: lo = BYTES;
    endcase
    return a >= lo;
  endfunction

  function automatic bit [7:0] exp_status();
    if (m_busy) return 8'hFF;
    return {m_lock, 3'b000, m_lvl, m_wen, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s size=%0d actual=%h expected=%h", req, BYTES, act, exp);
    end
  endtask

  // One command cycle: k 0 idle, 1 set-wen, 2 clear-wen, 3 status write, 4 array write.
  task automatic step(string req, int k, bit [7:0] d, int a, bit pn, bit dn);
    bit eg_s, er_s, eg_a, er_a;
    @(negedge clk);
    c_en = (k == 1); c_dis = (k == 2); c_sw = (k == 3); c_aw = (k == 4);
    wd = d; ad = AW'(a); pin_n = pn; done_p = dn;
    #2;
    eg_s = 0; er_s = 0; eg_a = 0; er_a = 0;
    if (!m_busy) begin
      if (k == 3) begin
        eg_s = m_wen && !(m_lock && !pn);
        er_s = !eg_s;
      end
      if (k == 4) begin
        eg_a = m_wen && !guarded(m_lvl, a);
        er_a = !eg_a;
      end
    end
    check(req, {28'd0, sg, sr, ag, ar}, {28'd0, eg_s, er_s, eg_a, er_a});
    @(posedge clk);
    #1;
    if (m_busy) begin
      if (dn) begin m_busy = 0; m_wen = 0; end
    end else begin
      if (k == 1) m_wen = 1;
      if (k == 2) m_wen = 0;
      if (eg_s) begin m_lock = d[7]; m_lvl = d[3:2]; m_busy = 1; end
      if (eg_a) m_busy = 1;
    end
    c_en = 0; c_dis = 0; c_sw = 0; c_aw = 0; done_p = 0;
    @(negedge clk);
    check(req, {23'd0, bz, st}, {23'd0, m_busy, exp_status()});
  endtask

  task automatic finish_cycle(string req);
    step(req, 0, 8'h00, 0, pin_n, 1'b1);
  endtask

  task automatic set_level(bit [1:0] lv, bit lk);
    step("R11", 1, 0, 0, 1, 0);
    step("R11", 3, {lk, 3'b000, lv, 2'b00}, 0, 1, 0);
    finish_cycle("R10");
  endtask

  task automatic probe(string req, int a);
    step(req, 1, 0, 0, pin_n, 0);
    step(req, 4, 0, a, pin_n, 0);
    if (m_busy) finish_cycle("R10");
  endtask

  initial begin
    int bound;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {23'd0, bz, st}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {23'd0, bz, st}, 32'd0);

    // R2: latch set and clear
    step("R2", 1, 0, 0, 1, 0);
    step("R2", 2, 0, 0, 1, 0);

    // R4: with write-enable clear both kinds are refused
    step("R4", 3, 8'h8C, 0, 1, 0);
    step("R4", 4, 0, 0, 1, 0);

    // R5 / R12: every level, both sides of each bound
    for (int lv = 0; lv < 4; lv++) begin
      set_level(2'(lv), 1'b0);
      bound = (lv == 1) ? BYTES - BYTES / 4 : (lv == 2) ? BYTES / 2 : (lv == 3) ? 0 : BYTES;
      if (bound > 0) probe("R12", bound - 1);
      if (bound < BYTES) probe("R12", bound);
      probe("R5", BYTES - 1);
      probe("R5", 0);
    end

    // R6: full fence with pin low and lock set, enable on
    set_level(2'd3, 1'b1);
    pin_n = 0;
    step("R6", 1, 0, 0, 0, 0);
    step("R6", 4, 0, BYTES / 3, 0, 0);
    step("R6", 2, 0, 0, 0, 0);
    step("R6", 4, 0, 5, 0, 0);
    pin_n = 1;

    // R7: spare bits dropped
    step("R7", 1, 0, 0, 1, 0);
    step("R7", 3, 8'h73, 0, 1, 0);
    finish_cycle("R7");

    // R8: hardware lock blocks status but not array
    set_level(2'd0, 1'b1);
    step("R8", 1, 0, 0, 0, 0);
    step("R8", 3, 8'h0C, 0, 0, 0);
    step("R8", 4, 0, BYTES - 1, 0, 0);
    finish_cycle("R8");

    // R9: lock cannot be cleared with pin low, can with pin high
    step("R9", 1, 0, 0, 0, 0);
    step("R9", 3, 8'h00, 0, 0, 0);
    step("R9", 3, 8'h00, 0, 1, 0);
    finish_cycle("R9");

    // R3 / R10: commands during a cycle are ignored; completion clears enable
    step("R10", 1, 0, 0, 1, 0);
    step("R10", 4, 0, 1, 1, 0);
    step("R3", 1, 0, 0, 1, 0);
    step("R3", 2, 0, 0, 1, 0);
    step("R3", 3, 8'h8C, 0, 1, 0);
    step("R3", 4, 0, 2, 1, 0);
    step("R10", 0, 0, 0, 1, 0);
    finish_cycle("R10");
    step("R10", 0, 0, 0, 1, 1);

    // Random command mix
    for (int i = 0; i < 600; i++) begin
      int k;
      bit dn;
      k  = int'($urandom_range(0, 4));
      dn = m_busy && ($urandom_range(0, 9) < 4);
      step("R3/R4/R5/R8/R10", k, 8'($urandom), int'($urandom_range(0, BYTES - 1)),
           1'($urandom_range(0, 1)), dn);
    end
    finished = 1;
  end
endmodule

module eeprom_wprot_status_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  wprot_bench #(.BYTES(16384), .SEED(11)) u_b16 ();
  wprot_bench #(.BYTES(32768), .SEED(23)) u_b32 ();

  initial begin
    int cycles = 0;
    int wd_bad = 0;
    while (!(u_b16.finished && u_b32.finished) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(u_b16.finished && u_b32.finished)) begin
      wd_bad = 1;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
    end
    $display("  test done: total=%0d bad=%0d",
             u_b16.n_chk + u_b32.n_chk + wd_bad, u_b16.n_bad + u_b32.n_bad + wd_bad);
    $finish;
  end
endmodule